// File: doc/BRIEF.md
# Address-Framed Serial Packet Receiver

This block takes an asynchronous serial line, such as the receive side of a half-duplex RS-485 transceiver, and turns it into whole packets. Each character on the line carries eight data bits plus a ninth flag bit that marks an address character. A packet is one flagged address character followed by sixteen unflagged data characters, seventeen characters in all. Only a flagged character that carries this node's address opens a packet. The sixteen data characters that follow are gathered into one wide word and offered to the consumer on a valid/ready output, all at once.

The serial line cannot be stalled, so back-pressure ends at the output slot. A finished packet is held on `pkt_data_o` with `pkt_valid_o` high until the consumer raises `pkt_ready_i`. A packet that finishes while the slot is still full, and is not being taken in that cycle, is discarded. A link-loss watchdog counts clock cycles since the last packet entered the slot. When the count reaches the configured window, it raises `failsafe_o`, which the motor stage uses to disable its drive.

At the default settings the clock runs at 100 MHz and there is one oversampling tick per clock. That gives a 6.25 Mbit/s line rate. The watchdog window is 25000 cycles, which is one 200 µs control cycle plus a 25 % margin.

Top module: `addr_pkt_rx`

## Requirements
- R1: The line idles high. A character is a low start bit, 8 data bits sent least significant first, an address-flag bit, and a high stop bit. Each bit lasts OVS ticks and is sampled at its middle. A low pulse shorter than half a bit does not start a character.
- R2: A packet opens only on a flagged character whose data equals NODE_ADDR (default 1). A flagged character with any other value is ignored, and so is an unflagged character received while no packet is open.
- R3: After the header, exactly DATA_BYTES (16) unflagged characters are collected and released together with one rise of `pkt_valid_o`. Data character k (k = 0 first) appears on `pkt_data_o[8k+7:8k]`.
- R4: A flagged character that arrives while a packet is being collected discards the partial packet. That character is then handled as a new header under R2.
- R5: A character with a low stop bit discards the packet being collected. Nothing is released for it and the watchdog is not reloaded.
- R6: While `pkt_valid_o` is high and `pkt_ready_i` is low, `pkt_valid_o` and `pkt_data_o` hold. One cycle after a cycle with both high, `pkt_valid_o` is low, unless a new packet was loaded at that same edge.
- R7: A packet that completes while the slot is full and not being taken is dropped. The held packet stays unchanged, and nothing is queued behind it.
- R8: `failsafe_o` is high from reset until the first packet is accepted. It is low in the cycle after any packet is accepted into the output slot.
- R9: `failsafe_o` rises once TIMEOUT_CYCLES clock cycles pass with no accepted packet. Rejected, corrupted and dropped packets do not reload the watchdog.
- R10: During and right after reset, `pkt_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; OVS × TICK_DIV cycles per serial bit |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, asynchronous to clk_i |
| pkt_valid_o | output | 1 | Output slot holds a complete packet |
| pkt_ready_i | input | 1 | Consumer takes the packet this cycle when valid |
| pkt_data_o | output | DATA_BYTES×8 | Packet data, first data character in the low byte |
| failsafe_o | output | 1 | Link lost: no accepted packet within the window |

## Verification
A packet enters the output slot at most four clock cycles after the middle of its last stop bit. That delay comes from two synchroniser stages, the sample, and the assembler register. `failsafe_o` falls one cycle after that. The bench always finishes driving the full stop bit and a one-bit idle gap before it samples, so every result is already settled when it is read. Handshake results are read at the falling edge after the rising edge that carries `pkt_ready_i`. Watchdog results are read well clear of the window edge: either a few thousand cycles after a packet, or fifty cycles past the full window.

// File: rtl/addr_pkt_rx_pkg.sv
package addr_pkt_rx_pkg;

  localparam int CHAR_W = 8;

  // One received character: address flag plus data.
  typedef struct packed {
    logic              flag;
    logic [CHAR_W-1:0] data;
  } rx_char_t;

  typedef enum logic [1:0] {
    LN_IDLE,
    LN_START,
    LN_BITS,
    LN_STOP
  } line_state_e;

  typedef enum logic {
    AS_HUNT,
    AS_FILL
  } asm_state_e;

endpackage

// File: rtl/sr_char_rx.sv
module sr_char_rx
  import addr_pkt_rx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int TICK_DIV = 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     rx_i,
  output logic     char_vld_o,
  output rx_char_t char_o,
  output logic     stop_err_o
);

  localparam int NBITS = CHAR_W + 1;
  localparam int OC_W  = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int BI_W  = $clog2(NBITS);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [OC_W-1:0] MID  = OC_W'(OVS / 2 - 1);
  localparam logic [OC_W-1:0] LAST = OC_W'(OVS - 1);

  logic tick;

  generate
    if (TICK_DIV > 1) begin : g_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else if (div_q == DIV_W'(TICK_DIV - 1)) div_q <= '0;
        else div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DIV_W'(TICK_DIV - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  // Two-stage synchroniser, idle high.
  logic [1:0] sync_q;
  logic       rx_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end
  assign rx_s = sync_q[1];

  line_state_e      st_q;
  logic [OC_W-1:0]  oc_q;
  logic [BI_W-1:0]  bi_q;
  logic [NBITS-1:0] sh_q;
  logic             vld_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= LN_IDLE;
      oc_q  <= '0;
      bi_q  <= '0;
      sh_q  <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
      unique case (st_q)
        LN_IDLE: begin
          if (!rx_s) begin
            st_q <= LN_START;
            oc_q <= '0;
          end
        end
        LN_START: begin
          if (tick) begin
            if (oc_q == MID) begin
              oc_q <= '0;
              bi_q <= '0;
              st_q <= rx_s ? LN_IDLE : LN_BITS;
            end else begin
              oc_q <= oc_q + 1'b1;
            end
          end
        end
        LN_BITS: begin
          if (tick) begin
            if (oc_q == LAST) begin
              oc_q <= '0;
              sh_q <= {rx_s, sh_q[NBITS-1:1]};
              if (bi_q == BI_W'(NBITS - 1)) st_q <= LN_STOP;
              else                          bi_q <= bi_q + 1'b1;
            end else begin
              oc_q <= oc_q + 1'b1;
            end
          end
        end
        LN_STOP: begin
          if (tick) begin
            if (oc_q == LAST) begin
              oc_q <= '0;
              st_q <= LN_IDLE;
              if (rx_s) vld_q <= 1'b1;
              else      err_q <= 1'b1;
            end else begin
              oc_q <= oc_q + 1'b1;
            end
          end
        end
        default: st_q <= LN_IDLE;
      endcase
    end
  end

  assign char_vld_o  = vld_q;
  assign stop_err_o  = err_q;
  assign char_o.flag = sh_q[NBITS-1];
  assign char_o.data = sh_q[CHAR_W-1:0];

endmodule

// File: rtl/pkt_assembler.sv
module pkt_assembler
  import addr_pkt_rx_pkg::*;
#(
  parameter int DATA_BYTES = 16,
  parameter int NODE_ADDR  = 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       char_vld_i,
  input  rx_char_t                   char_i,
  input  logic                       stop_err_i,
  input  logic                       pkt_ready_i,
  output logic                       pkt_valid_o,
  output logic [DATA_BYTES*CHAR_W-1:0] pkt_data_o,
  output logic                       accept_o
);

  localparam int PKT_W = DATA_BYTES * CHAR_W;
  localparam int CNT_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
  localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(DATA_BYTES - 1);
  localparam logic [CHAR_W-1:0] MY_ADDR  = CHAR_W'(NODE_ADDR);

  asm_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PKT_W-1:0] fill_q, fill_next;
  logic [PKT_W-1:0] out_q;
  logic             out_vld_q, acc_q;
  logic             slot_free;

  always_comb begin
    fill_next = fill_q;
    fill_next[int'(cnt_q)*CHAR_W +: CHAR_W] = char_i.data;
  end

  assign slot_free = !out_vld_q || pkt_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= AS_HUNT;
      cnt_q     <= '0;
      fill_q    <= '0;
      out_q     <= '0;
      out_vld_q <= 1'b0;
      acc_q     <= 1'b0;
    end else begin
      acc_q <= 1'b0;
      if (out_vld_q && pkt_ready_i) out_vld_q <= 1'b0;
      if (stop_err_i) begin
        st_q  <= AS_HUNT;
        cnt_q <= '0;
      end else if (char_vld_i) begin
        if (char_i.flag) begin
          st_q  <= (char_i.data == MY_ADDR) ? AS_FILL : AS_HUNT;
          cnt_q <= '0;
        end else if (st_q == AS_FILL) begin
          fill_q <= fill_next;
          if (cnt_q == LAST_IDX) begin
            st_q  <= AS_HUNT;
            cnt_q <= '0;
            if (slot_free) begin
              out_q     <= fill_next;
              out_vld_q <= 1'b1;
              acc_q     <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign pkt_valid_o = out_vld_q;
  assign pkt_data_o  = out_q;
  assign accept_o    = acc_q;

endmodule

// File: rtl/link_watchdog.sv
module link_watchdog #(
  parameter int TIMEOUT_CYCLES = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reload_i,
  output logic expired_o
);

  localparam int W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [W-1:0] LIMIT = W'(TIMEOUT_CYCLES);

  logic [W-1:0] cnt_q;

  // Starts expired so the drive stays off until the link is proven.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= LIMIT;
    else if (reload_i)       cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIMIT);

endmodule

// File: rtl/addr_pkt_rx.sv
module addr_pkt_rx
  import addr_pkt_rx_pkg::*;
#(
  parameter int OVS            = 16,
  parameter int TICK_DIV       = 1,
  parameter int DATA_BYTES     = 16,
  parameter int NODE_ADDR      = 1,
  parameter int TIMEOUT_CYCLES = 25000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rx_i,
  output logic                         pkt_valid_o,
  input  logic                         pkt_ready_i,
  output logic [DATA_BYTES*CHAR_W-1:0] pkt_data_o,
  output logic                         failsafe_o
);

  localparam int PKT_W = DATA_BYTES * CHAR_W;

  logic     char_vld;
  rx_char_t char_w;
  logic     stop_err;
  logic     pkt_accept;

  sr_char_rx #(
    .OVS      (OVS),
    .TICK_DIV (TICK_DIV)
  ) u_char_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_i       (rx_i),
    .char_vld_o (char_vld),
    .char_o     (char_w),
    .stop_err_o (stop_err)
  );

  pkt_assembler #(
    .DATA_BYTES (DATA_BYTES),
    .NODE_ADDR  (NODE_ADDR)
  ) u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .char_vld_i  (char_vld),
    .char_i      (char_w),
    .stop_err_i  (stop_err),
    .pkt_ready_i (pkt_ready_i),
    .pkt_valid_o (pkt_valid_o),
    .pkt_data_o  (pkt_data_o),
    .accept_o    (pkt_accept)
  );

  link_watchdog #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .reload_i  (pkt_accept),
    .expired_o (failsafe_o)
  );

endmodule

// File: rtl/addr_pkt_rx_chk.sv
module addr_pkt_rx_chk #(
  parameter int PKT_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             char_vld,
  input logic             stop_err,
  input logic             pkt_accept,
  input logic             pkt_valid,
  input logic             pkt_ready,
  input logic [PKT_W-1:0] pkt_data,
  input logic             failsafe
);

  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_data)); // R6

  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid && pkt_ready |=> !pkt_valid || pkt_accept); // R6

  AST_LOAD_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_accept |-> pkt_valid); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_accept |=> !pkt_accept); // R7

  AST_FS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_accept |=> !failsafe); // R8

  AST_FS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(failsafe) |-> !$past(pkt_accept)); // R9

  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_err |-> !char_vld); // R5

endmodule

bind addr_pkt_rx addr_pkt_rx_chk #(.PKT_W(PKT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .char_vld   (char_vld),
  .stop_err   (stop_err),
  .pkt_accept (pkt_accept),
  .pkt_valid  (pkt_valid_o),
  .pkt_ready  (pkt_ready_i),
  .pkt_data   (pkt_data_o),
  .failsafe   (failsafe_o)
);

// File: tb/test_addr_pkt_rx.sv
module test_addr_pkt_rx;

  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 16;
  localparam int NB         = 16;
  localparam int PW         = NB * 8;
  localparam int TO         = 6000;
  localparam logic [4:0] NO_ERR = 5'd31;

  // {addr[22:15], hdr_flag[14], err_pos[13:9], expect[8], seed[7:0]}
  localparam logic [22:0] VEC [7] = '{
    {8'd1, 1'b1, NO_ERR, 1'b1, 8'h3C},  // R3 good packet
    {8'd2, 1'b1, NO_ERR, 1'b0, 8'h55},  // R2 foreign address
    {8'd1, 1'b0, NO_ERR, 1'b0, 8'h66},  // R2 header without flag
    {8'd1, 1'b1, 5'd5,   1'b0, 8'h77},  // R5 stop error mid packet
    {8'd0, 1'b1, NO_ERR, 1'b0, 8'h12},  // R2 address zero
    {8'd1, 1'b1, 5'd15,  1'b0, 8'h21},  // R5 stop error on last byte
    {8'd1, 1'b1, NO_ERR, 1'b1, 8'hA5}   // R3 good packet
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx = 1'b1;
  logic          ready = 1'b0;
  logic          valid;
  logic [PW-1:0] data;
  logic          fs;
  int            n_tests = 0;
  int            n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  addr_pkt_rx #(
    .OVS(OVS), .TICK_DIV(1), .DATA_BYTES(NB), .NODE_ADDR(1), .TIMEOUT_CYCLES(TO)
  ) i_addr_pkt_rx (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx),
    .pkt_valid_o(valid), .pkt_ready_i(ready), .pkt_data_o(data), .failsafe_o(fs)
  );

  function automatic logic [PW-1:0] exp_pkt(input logic [7:0] seed);
    logic [PW-1:0] r;
    for (int k = 0; k < NB; k++) r[k*8 +: 8] = seed + 8'(k * 37);
    return r;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [PW-1:0] act,
                       input logic [PW-1:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic bit_out(input logic v);
    rx = v;
    repeat (OVS) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input logic flag, input logic stop);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(d[i]);
    bit_out(flag);
    bit_out(stop);
    bit_out(1'b1);
  endtask

  task automatic send_pkt(input logic [7:0] addr, input logic hflag,
                          input logic [4:0] errpos, input logic [7:0] seed);
    send_char(addr, hflag, 1'b1);
    for (int k = 0; k < NB; k++)
      send_char(seed + 8'(k * 37), 1'b0, (5'(k) != errpos));
  endtask

  task automatic take;
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10 R8 reset state
    check(valid == 1'b0, "R10 valid in reset", PW'(valid), '0);
    check(fs == 1'b1, "R8 failsafe in reset", PW'(fs), PW'(1));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(valid == 1'b0 && fs == 1'b1, "R10 R8 after reset", PW'({valid, fs}), PW'(1));

    // Vector walk: R1 R2 R3 R5 R6 R8
    for (int v = 0; v < 7; v++) begin
      logic [22:0] e;
      e = VEC[v];
      send_pkt(e[22:15], e[14], e[13:9], e[7:0]);
      check(valid == e[8], "R2 R3 R5 packet release", PW'(valid), PW'(e[8]));
      if (e[8]) begin
        check(data == exp_pkt(e[7:0]), "R1 R3 packet data", data, exp_pkt(e[7:0]));
        check(fs == 1'b0, "R8 failsafe after accept", PW'(fs), '0);
        repeat (40) @(negedge clk);
        check(valid && data == exp_pkt(e[7:0]), "R6 hold without ready", data,
              exp_pkt(e[7:0]));
        take();
        check(valid == 1'b0, "R6 release after handshake", PW'(valid), '0);
      end
    end

    // R1 short glitch ignored, then a good packet
    rx = 1'b0;
    repeat (5) @(negedge clk);
    rx = 1'b1;
    repeat (40) @(negedge clk);
    check(valid == 1'b0, "R1 glitch no packet", PW'(valid), '0);
    send_pkt(8'd1, 1'b1, NO_ERR, 8'h5A);
    check(valid && data == exp_pkt(8'h5A), "R1 packet after glitch", data, exp_pkt(8'h5A));
    take();

    // R4 header in the middle of a packet restarts collection
    send_char(8'd1, 1'b1, 1'b1);
    for (int k = 0; k < 6; k++) send_char(8'hEE, 1'b0, 1'b1);
    send_pkt(8'd1, 1'b1, NO_ERR, 8'hC3);
    check(valid && data == exp_pkt(8'hC3), "R4 restart on header", data, exp_pkt(8'hC3));
    take();
    check(valid == 1'b0, "R4 single release", PW'(valid), '0);

    // R7 second packet while the slot is full is dropped
    send_pkt(8'd1, 1'b1, NO_ERR, 8'h10);
    send_pkt(8'd1, 1'b1, NO_ERR, 8'h90);
    check(valid && data == exp_pkt(8'h10), "R7 held packet kept", data, exp_pkt(8'h10));
    take();
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R7 nothing queued", PW'(valid), '0);

    // R9 watchdog window
    repeat (TO / 4) @(negedge clk);
    check(fs == 1'b0, "R9 failsafe low inside window", PW'(fs), '0);
    repeat (TO + 50) @(negedge clk);
    check(fs == 1'b1, "R9 failsafe after window", PW'(fs), PW'(1));
    send_pkt(8'd1, 1'b1, 5'd9, 8'h44);
    check(fs == 1'b1 && valid == 1'b0, "R5 corrupt packet no reload", PW'({fs, valid}),
          PW'(2));
    send_pkt(8'd3, 1'b1, NO_ERR, 8'h44);
    check(fs == 1'b1, "R9 foreign packet no reload", PW'(fs), PW'(1));
    send_pkt(8'd1, 1'b1, NO_ERR, 8'h44);
    check(fs == 1'b0 && valid, "R8 reload on accept", PW'({fs, valid}), PW'(1));
    take();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule